// File: doc/BRIEF.md
# GCI Line Activation Sequencer

This block sequences the bring-up and shut-down of a GCI line between a controller and a layer 1 device. While the line is down, the layer 1 device supplies no bit clock and the transmit data line idles at logic one. The sequencer samples the incoming bit clock into the system clock domain. A watchdog counter with a programmable timeout decides whether the bit clock is present. The sequencer also qualifies the channel 0 C/I nibbles that arrive once per frame. A code counts as a valid indication only when the same nonzero value arrives in two frames in a row.

Activation can start from either end. The layer 1 device can restart the bit clock and send a valid indication, which moves the line straight to the active state. The local core can instead hold its stuck-at-zero control high. The sequencer then drives the transmit data to zero and puts the timing command (C/I code 0) on channel 0 C/I. It keeps doing so until the layer 1 device answers and the core drops the control. Each valid indication that arrives while the bit clock runs sets a sticky interrupt bit. The core clears that bit by writing a one, and an enable bit gates it onto the interrupt line.

The controller has four states. In DEACT the line is down. CORE_ACT means the core has asked for activation and no answer has come yet. CORE_ACK means the answer has arrived while stuck-at-zero is still held. ACTIVE means normal data flows. The transitions are named as follows. T_CORE_REQ goes from DEACT to CORE_ACT. T_REMOTE_UP goes from DEACT to ACTIVE. T_ANSWER goes from CORE_ACT to CORE_ACK. T_ABORT goes from CORE_ACT to DEACT. T_RELEASE goes from CORE_ACK to ACTIVE. T_LOST_ACK goes from CORE_ACK to DEACT. T_CLK_LOSS goes from ACTIVE to DEACT.

Top module: `gci_act_seq`

## Requirements
- R1: After reset, state_code is 0 (DEACT), tx_data_o is 1, clk_present is 0, line_active is 0, irq_pend_o is 0 and irq_o is 0.
- R2: In DEACT with stz low, tx_data_o is 1 whatever tx_data_i is, and ci_tx_o equals ci_tx_i.
- R3: clk_present rises within 4 system clocks of a rising edge on bit_clk. It falls once no rising edge has been seen for timeout_cyc+1 system clocks after the last detected edge.
- R4: A frame is a one-cycle pulse on frame_stb that carries ci_rx. An indication is valid in the frame whose ci_rx is nonzero and equal to the ci_rx of the previous frame, and only in the first such frame of a run. Code 0 is never valid. ci_code_o holds the last valid code.
- R5: In DEACT with stz low, clk_present high and a valid indication, the next state is ACTIVE (state_code 3), and tx_data_o then follows tx_data_i (T_REMOTE_UP).
- R6: In DEACT with stz high, the next state is CORE_ACT (state_code 1). In CORE_ACT and CORE_ACK, tx_data_o is 0 and ci_tx_o is 4'h0, the timing command (T_CORE_REQ).
- R7: CORE_ACT moves to CORE_ACK (state_code 2) on a valid indication with clk_present high (T_ANSWER). CORE_ACT returns to DEACT if stz falls first (T_ABORT). CORE_ACK moves to ACTIVE when stz falls with clk_present high (T_RELEASE), and to DEACT when stz falls without it (T_LOST_ACK).
- R8: A valid indication while clk_present is high sets irq_pend_o on the next cycle. irq_o equals irq_pend_o AND irq_enable.
- R9: A pulse on irq_clr clears irq_pend_o on the next cycle, unless a new valid indication arrives in the same cycle, in which case irq_pend_o stays set.
- R10: ACTIVE returns to DEACT one cycle after clk_present falls (T_CLK_LOSS). stz has no effect in ACTIVE.
- R11: A valid indication while clk_present is low changes neither the state nor irq_pend_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Line bit clock from the layer 1 device, asynchronous |
| timeout_cyc | input | 16 | Bit clock absence timeout in system clocks |
| frame_stb | input | 1 | One-cycle pulse marking a received channel 0 C/I nibble |
| ci_rx | input | 4 | Received channel 0 C/I code |
| stz | input | 1 | Core stuck-at-zero control |
| irq_enable | input | 1 | Interrupt enable (1 = pass pending to irq_o) |
| irq_clr | input | 1 | Write-one pulse clearing the pending interrupt |
| tx_data_i | input | 1 | Normal transmit data from the serial path |
| ci_tx_i | input | 4 | Normal channel 0 C/I transmit code |
| tx_data_o | output | 1 | Transmit data toward the line |
| ci_tx_o | output | 4 | Channel 0 C/I code to transmit |
| clk_present | output | 1 | Bit clock detected as running |
| line_active | output | 1 | Controller is in ACTIVE |
| state_code | output | 2 | 0 DEACT, 1 CORE_ACT, 2 CORE_ACK, 3 ACTIVE |
| ci_code_o | output | 4 | Last valid C/I code |
| irq_pend_o | output | 1 | Sticky interrupt pending |
| irq_o | output | 1 | Gated interrupt |

## Verification
The assertions check several rules on every cycle. The line never stays active one cycle past a loss of the bit clock. The pending bit rises only after a valid indication seen with the clock running. A clear pulse with no competing indication always empties the pending bit. A valid indication always comes with a strobe and a nonzero code. clk_present only rises after a detected bit clock edge. CORE_ACK leaves for ACTIVE only once stz has dropped. The bench scenarios show the outcomes that depend on a sequence of events. These are the two-frame qualification, including zero codes and mismatched pairs. They also cover the remote and core-initiated bring-up paths, the abort path, set-over-clear priority, the gating by irq_enable, and the clock-timeout window.

// File: rtl/gci_act_pkg.sv
package gci_act_pkg;

    typedef enum logic [1:0] {
        ST_DEACT    = 2'd0,
        ST_CORE_ACT = 2'd1,
        ST_CORE_ACK = 2'd2,
        ST_ACTIVE   = 2'd3
    } act_state_t;

    localparam int CI_W = 4;
    localparam logic [CI_W-1:0] CI_TIM = '0;

endpackage

// File: rtl/gci_clk_mon.sv
module gci_clk_mon #(
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk,
    input  logic [CNT_W-1:0] timeout_cyc,
    output logic             present_o
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0]  sync_q;
    logic             edge_seen;
    logic [CNT_W-1:0] idle_cnt_q;
    logic             present_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SH_W-2:0], bit_clk};
        end
    end

    assign edge_seen = sync_q[SH_W-2] & ~sync_q[SH_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt_q <= '0;
            present_q  <= 1'b0;
        end else if (edge_seen) begin
            idle_cnt_q <= '0;
            present_q  <= 1'b1;
        end else if (idle_cnt_q >= timeout_cyc) begin
            present_q  <= 1'b0;
        end else begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    assign present_o = present_q;

    // R3: presence is only ever declared after a detected bit clock edge
    p_present_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present_q) |-> $past(edge_seen));

endmodule

// File: rtl/gci_ci_qual.sv
module gci_ci_qual
    import gci_act_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic [CI_W-1:0] ci_rx,
    output logic            ind_valid_o,
    output logic [CI_W-1:0] code_o
);

    logic [CI_W-1:0] prev_q;
    logic            run_q;
    logic [CI_W-1:0] code_q;
    logic            pair_match;

    assign pair_match  = (ci_rx == prev_q) && (ci_rx != CI_TIM);
    assign ind_valid_o = frame_stb && pair_match && !run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            run_q  <= 1'b0;
            code_q <= '0;
        end else begin
            if (frame_stb) begin
                prev_q <= ci_rx;
                run_q  <= pair_match;
            end
            if (ind_valid_o) begin
                code_q <= ci_rx;
            end
        end
    end

    assign code_o = code_q;

    // R4: a valid indication needs a strobed, nonzero code
    p_valid_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ind_valid_o |-> (frame_stb && (ci_rx != '0)));

endmodule

// File: rtl/gci_irq_stat.sv
module gci_irq_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic enable_i,
    output logic pend_o,
    output logic irq_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & enable_i;

    // R8: pending rises only after a qualifying set request
    p_pend_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(set_i));

    // R9: a clear without a competing set empties the bit
    p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_q);

endmodule

// File: rtl/gci_act_fsm.sv
module gci_act_fsm
    import gci_act_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_present,
    input  logic            ind_valid,
    input  logic            stz,
    input  logic            tx_data_i,
    input  logic [CI_W-1:0] ci_tx_i,
    output logic            tx_data_o,
    output logic [CI_W-1:0] ci_tx_o,
    output act_state_t      state_o
);

    act_state_t state_q;
    act_state_t state_d;
    logic       answer;

    assign answer = ind_valid && clk_present;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DEACT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DEACT: begin
                if (stz) begin
                    state_d = ST_CORE_ACT;      // T_CORE_REQ
                end else if (answer) begin
                    state_d = ST_ACTIVE;        // T_REMOTE_UP
                end
            end
            ST_CORE_ACT: begin
                if (!stz) begin
                    state_d = ST_DEACT;         // T_ABORT
                end else if (answer) begin
                    state_d = ST_CORE_ACK;      // T_ANSWER
                end
            end
            ST_CORE_ACK: begin
                if (!stz) begin
                    state_d = clk_present ? ST_ACTIVE    // T_RELEASE
                                          : ST_DEACT;    // T_LOST_ACK
                end
            end
            ST_ACTIVE: begin
                if (!clk_present) begin
                    state_d = ST_DEACT;         // T_CLK_LOSS
                end
            end
            default: state_d = ST_DEACT;
        endcase
    end

    always_comb begin
        tx_data_o = 1'b1;
        ci_tx_o   = ci_tx_i;
        unique case (state_q)
            ST_DEACT: begin
                tx_data_o = 1'b1;
                ci_tx_o   = ci_tx_i;
            end
            ST_CORE_ACT, ST_CORE_ACK: begin
                tx_data_o = 1'b0;
                ci_tx_o   = CI_TIM;
            end
            ST_ACTIVE: begin
                tx_data_o = tx_data_i;
                ci_tx_o   = ci_tx_i;
            end
            default: begin
                tx_data_o = 1'b1;
                ci_tx_o   = ci_tx_i;
            end
        endcase
    end

    assign state_o = state_q;

    // R7: the acknowledged core request is released only after stz drops
    p_release_needs_stz_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_CORE_ACK && state_q == ST_ACTIVE) |-> !$past(stz));

    // R11: no activation from DEACT while the bit clock is absent
    p_no_remote_up_without_clk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEACT && !clk_present) |=> (state_q != ST_ACTIVE));

endmodule

// File: rtl/gci_act_seq.sv
module gci_act_seq
    import gci_act_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk,
    input  logic [CNT_W-1:0] timeout_cyc,
    input  logic             frame_stb,
    input  logic [3:0]       ci_rx,
    input  logic             stz,
    input  logic             irq_enable,
    input  logic             irq_clr,
    input  logic             tx_data_i,
    input  logic [3:0]       ci_tx_i,
    output logic             tx_data_o,
    output logic [3:0]       ci_tx_o,
    output logic             clk_present,
    output logic             line_active,
    output logic [1:0]       state_code,
    output logic [3:0]       ci_code_o,
    output logic             irq_pend_o,
    output logic             irq_o
);

    logic       present;
    logic       ind_valid;
    act_state_t state;

    gci_clk_mon #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_clk_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_clk     (bit_clk),
        .timeout_cyc (timeout_cyc),
        .present_o   (present)
    );

    gci_ci_qual u_ci_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (frame_stb),
        .ci_rx       (ci_rx),
        .ind_valid_o (ind_valid),
        .code_o      (ci_code_o)
    );

    gci_act_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_present (present),
        .ind_valid   (ind_valid),
        .stz         (stz),
        .tx_data_i   (tx_data_i),
        .ci_tx_i     (ci_tx_i),
        .tx_data_o   (tx_data_o),
        .ci_tx_o     (ci_tx_o),
        .state_o     (state)
    );

    gci_irq_stat u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ind_valid && present),
        .clr_i    (irq_clr),
        .enable_i (irq_enable),
        .pend_o   (irq_pend_o),
        .irq_o    (irq_o)
    );

    assign clk_present = present;
    assign state_code  = state;
    assign line_active = (state == ST_ACTIVE);

    // R10: losing the bit clock never leaves the line active
    p_loss_deactivates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> !line_active);

endmodule

// File: tb/sim_gci_act_seq.sv
module sim_gci_act_seq;

    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk = 1'b0;
    logic        bclk_run = 1'b0;
    logic [15:0] timeout_cyc = 16'(TMO);
    logic        frame_stb = 1'b0;
    logic [3:0]  ci_rx = '0;
    logic        stz = 1'b0;
    logic        irq_enable = 1'b0;
    logic        irq_clr = 1'b0;
    logic        tx_data_i = 1'b0;
    logic [3:0]  ci_tx_i = 4'hA;
    logic        tx_data_o;
    logic [3:0]  ci_tx_o;
    logic        clk_present;
    logic        line_active;
    logic [1:0]  state_code;
    logic [3:0]  ci_code_o;
    logic        irq_pend_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    gci_act_seq u0 (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .timeout_cyc(timeout_cyc),
        .frame_stb(frame_stb), .ci_rx(ci_rx), .stz(stz), .irq_enable(irq_enable),
        .irq_clr(irq_clr), .tx_data_i(tx_data_i), .ci_tx_i(ci_tx_i),
        .tx_data_o(tx_data_o), .ci_tx_o(ci_tx_o), .clk_present(clk_present),
        .line_active(line_active), .state_code(state_code), .ci_code_o(ci_code_o),
        .irq_pend_o(irq_pend_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            if (bclk_run) begin
                #32 bit_clk = 1'b1;
                #32 bit_clk = 1'b0;
            end else begin
                #8;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(input logic [3:0] code);
        frame_stb = 1'b1;
        ci_rx     = code;
        @(negedge clk);
        frame_stb = 1'b0;
        cycles(2);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        eq("R1 state", state_code, 0);
        eq("R1 tx_data_o", tx_data_o, 1);
        eq("R1 clk_present", clk_present, 0);
        eq("R1 line_active", line_active, 0);
        eq("R1 irq_pend", irq_pend_o, 0);
        eq("R1 irq", irq_o, 0);
        tx_data_i = 1'b0;
        @(negedge clk);
        eq("R2 idle line high", tx_data_o, 1);
        eq("R2 ci passthrough", ci_tx_o, 4'hA);
    endtask

    task automatic t_clock_monitor();
        bclk_run = 1'b1;
        cycles(24);
        eq("R3 present while running", clk_present, 1);
        bclk_run = 1'b0;
        cycles(8);
        cycles(TMO - 12);
        eq("R3 still present before timeout", clk_present, 1);
        cycles(24);
        eq("R3 absent after timeout", clk_present, 0);
    endtask

    task automatic t_no_clock_indication();
        frame(4'h5);
        frame(4'h5);
        eq("R11 state unchanged", state_code, 0);
        eq("R11 no pending", irq_pend_o, 0);
        eq("R4 code recorded", ci_code_o, 5);
    endtask

    task automatic t_remote_up();
        bclk_run = 1'b1;
        cycles(24);
        frame(4'h0);
        frame(4'h0);
        eq("R4 zero code not valid", state_code, 0);
        frame(4'h3);
        frame(4'h6);
        eq("R4 mismatched pair not valid", state_code, 0);
        eq("R4 mismatched no pending", irq_pend_o, 0);
        frame(4'h6);
        eq("R5 remote activation", state_code, 3);
        eq("R5 line_active", line_active, 1);
        eq("R4 code 6", ci_code_o, 6);
        eq("R8 pending set", irq_pend_o, 1);
        eq("R8 irq masked", irq_o, 0);
        irq_enable = 1'b1;
        @(negedge clk);
        eq("R8 irq enabled", irq_o, 1);
        tx_data_i = 1'b0;
        @(negedge clk);
        eq("R5 data follows 0", tx_data_o, 0);
        tx_data_i = 1'b1;
        stz = 1'b1;
        cycles(2);
        eq("R10 stz ignored state", state_code, 3);
        eq("R10 stz ignored data", tx_data_o, 1);
        stz = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_irq_clear();
        clear_irq();
        eq("R9 cleared", irq_pend_o, 0);
        frame(4'h6);
        eq("R4 repeat of run not revalid", irq_pend_o, 0);
        frame(4'h7);
        frame_stb = 1'b1;
        ci_rx     = 4'h7;
        irq_clr   = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        irq_clr   = 1'b0;
        eq("R9 set wins over clear", irq_pend_o, 1);
        clear_irq();
    endtask

    task automatic t_clock_loss();
        bclk_run = 1'b0;
        cycles(TMO + 24);
        eq("R10 deactivated on clock loss", state_code, 0);
        eq("R2 line high again", tx_data_o, 1);
    endtask

    task automatic t_core_act();
        ci_tx_i = 4'hF;
        stz = 1'b1;
        @(negedge clk);
        eq("R6 core request state", state_code, 1);
        eq("R6 data forced low", tx_data_o, 0);
        eq("R6 timing command", ci_tx_o, 0);
        stz = 1'b0;
        @(negedge clk);
        eq("R7 abort to deact", state_code, 0);
        stz = 1'b1;
        bclk_run = 1'b1;
        cycles(24);
        frame(4'h9);
        frame(4'h9);
        eq("R7 answered", state_code, 2);
        eq("R7 still forcing zero", tx_data_o, 0);
        eq("R8 answer raises pending", irq_pend_o, 1);
        stz = 1'b0;
        @(negedge clk);
        eq("R7 release to active", state_code, 3);
        eq("R7 ci passthrough", ci_tx_o, 4'hF);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clock_monitor();
        t_no_clock_indication();
        t_remote_up();
        t_irq_clear();
        t_clock_loss();
        t_core_act();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule